// File: doc/BRIEF.md
# Receive Frame Error and Status Classifier

This block watches an Ethernet frame as it arrives one byte per cycle, framed by start and end markers and qualified by a valid strobe. While bytes go by, it records the group bit of the destination address, walks over up to two VLAN tags and picks out the Length/Type word and the two bytes after it. It also notes any non-terminate control character flagged by the line decoder, and counts every byte of the frame.

On the beat that carries the last byte, the block decides. The result is a 2-bit error code, an error flag and a 3-bit status code, and all three are registered. They appear for exactly one cycle after that beat, marked by a done strobe. The frame check itself is done upstream, and its verdict arrives as an input on the last beat. The maximum frame length is a live input, so software-held configuration elsewhere can change it between frames.

Top module: `rxcls_top`

## Requirements
- R1: `out_done` is high for exactly one cycle, the cycle after a beat with `in_valid` and `in_eop` both high. Whenever `out_done` is low, `err_code`, `err_flag` and `status_code` are all zero, and they are all zero after reset.
- R2: If `in_ctrl_bad` was high on any valid beat from SOP to EOP inclusive, `err_code` is 1. This takes precedence over every other error.
- R3: Otherwise, if the frame length is below 64 or above `max_len`, `err_code` is 2. The frame length is the count of valid bytes from SOP to EOP inclusive, frame check bytes included.
- R4: Otherwise, if the Length/Type value T is at most 1500 and the frame length is less than T + H + 4, `err_code` is 3. H is the byte offset just past the Length/Type word. In all other cases `err_code` is 0.
- R5: `err_flag` is high when `err_code` is non-zero, or when `in_fcs_bad` was high on the EOP beat.
- R6: The Length/Type word occupies bytes 12 and 13. If that word is 0x8100 or 0x88A8, it is a tag, and the Length/Type word moves 4 bytes later, with H growing to match. At most two tags are skipped this way.
- R7: The status categories are as follows:
  - 5: the outer tag is 0x88A8, or there are two tags.
  - 4: T = 0x8808 and the next two bytes are 0x0101.
  - 7: T = 0x8808.
  - 6: T is 1501 to 1535, or the frame ended before T was complete.
  - 1: T ≥ 0x0600, other than 0x8808 and 0x88F7.
  - 2: bit 0 of byte 0 is set.
  - 3: T = 0x88F7.
  - 0: T ≤ 1500.
- R8: When several categories apply, `status_code` reports the first of them in the order 5, 4, 7, 6, 1, 2, 3, 0.
- R9: Beats with `in_valid` low change nothing, whatever the other inputs carry.
- R10: A valid beat with `in_sop` high starts a new frame and discards everything recorded for an unfinished earlier one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte beat qualifier |
| in_sop | input | 1 | First byte of a frame |
| in_eop | input | 1 | Last byte of a frame |
| in_byte | input | 8 | Frame byte |
| in_ctrl_bad | input | 1 | Non-terminate control character on this beat |
| in_fcs_bad | input | 1 | Frame check failed (sampled on EOP beat) |
| max_len | input | LEN_W | Largest allowed frame length in bytes |
| out_done | output | 1 | Classification valid strobe |
| err_code | output | 2 | Error code |
| err_flag | output | 1 | Frame is bad |
| status_code | output | 3 | Frame category |

## Verification
The assertions take for granted that `in_fcs_bad` is meaningful only on an EOP beat. They also assume that reset lasts at least one clock with `in_valid` low, so the done strobe can always be traced to a single earlier beat. The stimulus keeps within these limits: the frame-check input is raised only together with the last byte. Idle beats are inserted between bytes, and those idle beats deliberately carry stray start, end, control and frame-check values. This way R9 is tested against inputs that would change the result if they were taken.

// File: rtl/rxcls_pkg.sv
package rxcls_pkg;

  localparam logic [15:0] TPID_CUST     = 16'h8100;
  localparam logic [15:0] TPID_SERV     = 16'h88A8;
  localparam logic [15:0] ET_FLOWCTL    = 16'h8808;
  localparam logic [15:0] ET_PTP        = 16'h88F7;
  localparam logic [15:0] OPC_PRIO      = 16'h0101;
  localparam logic [15:0] LEN_FIELD_MAX = 16'd1500;
  localparam logic [15:0] ET_FLOOR      = 16'h0600;

  localparam int MIN_FRAME   = 64;
  localparam int FCS_BYTES   = 4;
  localparam int TYPE_OFS    = 12;
  localparam int TAG_BYTES   = 4;
  localparam int N_CAT       = 8;

  localparam logic [1:0] ERR_NONE  = 2'd0;
  localparam logic [1:0] ERR_CTRL  = 2'd1;
  localparam logic [1:0] ERR_SIZE  = 2'd2;
  localparam logic [1:0] ERR_SHORT = 2'd3;

  // fields gathered while a frame streams past
  typedef struct packed {
    logic        grp;
    logic        svl;
    logic        typ_ok;
    logic [15:0] typ;
    logic        opc_ok;
    logic [15:0] opc;
    logic        ctl_bad;
  } frm_info_t;

  // category reported at rank k (rank 0 wins)
  function automatic logic [2:0] prio_slot(input int k);
    case (k)
      0:       prio_slot = 3'd5;
      1:       prio_slot = 3'd4;
      2:       prio_slot = 3'd7;
      3:       prio_slot = 3'd6;
      4:       prio_slot = 3'd1;
      5:       prio_slot = 3'd2;
      6:       prio_slot = 3'd3;
      default: prio_slot = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/rxcls_hdr_parser.sv
module rxcls_hdr_parser
  import rxcls_pkg::*;
#(
  parameter int LEN_W    = 16,
  parameter int MAX_TAGS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_sop,
  input  logic [7:0]       in_byte,
  input  logic             in_ctrl,
  output logic [LEN_W-1:0] len_nxt,
  output logic [LEN_W-1:0] hend_nxt,
  output frm_info_t        info_nxt
);

  localparam logic [LEN_W-1:0] TPOS0  = LEN_W'(TYPE_OFS + 1);
  localparam logic [LEN_W-1:0] TAG_SZ = LEN_W'(TAG_BYTES);

  logic [LEN_W-1:0] cnt_q, hend_q;
  logic [1:0]       ntag_q, ntag_nxt;
  logic [7:0]       prev_q;
  frm_info_t        info_q;

  logic [LEN_W-1:0] idx, hend_b, tpos;
  logic [1:0]       ntag_b;
  frm_info_t        base;
  logic [15:0]      word;
  logic             is_tag;

  always_comb begin
    base     = in_sop ? '0 : info_q;
    idx      = in_sop ? '0 : cnt_q;
    hend_b   = in_sop ? '0 : hend_q;
    ntag_b   = in_sop ? 2'd0 : ntag_q;
    word     = {prev_q, in_byte};
    tpos     = TPOS0 + TAG_SZ * LEN_W'(ntag_b);
    is_tag   = (word == TPID_CUST) || (word == TPID_SERV);

    info_nxt = base;
    hend_nxt = hend_b;
    ntag_nxt = ntag_b;
    len_nxt  = (&idx) ? idx : idx + 1'b1;

    info_nxt.ctl_bad = base.ctl_bad | in_ctrl;
    if (idx == '0) info_nxt.grp = in_byte[0];

    if (!base.typ_ok && idx == tpos) begin
      if (is_tag && int'(ntag_b) < MAX_TAGS) begin
        ntag_nxt = ntag_b + 2'd1;
        if (word == TPID_SERV || ntag_b != 2'd0) info_nxt.svl = 1'b1;
      end else begin
        info_nxt.typ    = word;
        info_nxt.typ_ok = 1'b1;
        hend_nxt        = idx + 1'b1;
      end
    end

    if (base.typ_ok && !base.opc_ok && idx == hend_b + 1'b1) begin
      info_nxt.opc    = word;
      info_nxt.opc_ok = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      hend_q <= '0;
      ntag_q <= 2'd0;
      prev_q <= 8'd0;
      info_q <= '0;
    end else if (in_valid) begin
      cnt_q  <= len_nxt;
      hend_q <= hend_nxt;
      ntag_q <= ntag_nxt;
      prev_q <= in_byte;
      info_q <= info_nxt;
    end
  end

endmodule

// File: rtl/rxcls_err_eval.sv
module rxcls_err_eval
  import rxcls_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic [LEN_W-1:0] len,
  input  logic [LEN_W-1:0] hend,
  input  logic [LEN_W-1:0] max_len,
  input  logic             ctl_bad,
  input  logic             typ_ok,
  input  logic [15:0]      typ,
  output logic [1:0]       code
);

  localparam int EW = ((LEN_W > 16) ? LEN_W : 16) + 2;

  logic [EW-1:0] need, have;
  logic          bad_size, short_pay;

  always_comb begin
    need      = EW'(typ) + EW'(hend) + EW'(FCS_BYTES);
    have      = EW'(len);
    bad_size  = (have < EW'(MIN_FRAME)) || (len > max_len);
    short_pay = typ_ok && (typ <= LEN_FIELD_MAX) && (have < need);
    if (ctl_bad)        code = ERR_CTRL;
    else if (bad_size)  code = ERR_SIZE;
    else if (short_pay) code = ERR_SHORT;
    else                code = ERR_NONE;
  end

endmodule

// File: rtl/rxcls_status_prio.sv
module rxcls_status_prio
  import rxcls_pkg::*;
(
  input  logic        grp,
  input  logic        svl,
  input  logic        typ_ok,
  input  logic [15:0] typ,
  input  logic        opc_ok,
  input  logic [15:0] opc,
  output logic [2:0]  code
);

  logic [N_CAT-1:0] cat, hit;
  logic             is_fc;

  always_comb begin
    is_fc  = typ_ok && (typ == ET_FLOWCTL);
    cat    = '0;
    cat[5] = svl;
    cat[4] = is_fc && opc_ok && (opc == OPC_PRIO);
    cat[7] = is_fc;
    cat[6] = !typ_ok || ((typ > LEN_FIELD_MAX) && (typ < ET_FLOOR));
    cat[1] = typ_ok && (typ >= ET_FLOOR) && !is_fc && (typ != ET_PTP);
    cat[2] = grp;
    cat[3] = typ_ok && (typ == ET_PTP);
    cat[0] = typ_ok && (typ <= LEN_FIELD_MAX);
  end

  for (genvar g = 0; g < N_CAT; g++) begin : g_rank
    assign hit[g] = cat[prio_slot(g)];
  end

  always_comb begin
    code = 3'd0;
    for (int k = N_CAT - 1; k >= 0; k--) begin
      if (hit[k]) code = prio_slot(k);
    end
  end

endmodule

// File: rtl/rxcls_top.sv
module rxcls_top
  import rxcls_pkg::*;
#(
  parameter int LEN_W    = 16,
  parameter int MAX_TAGS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_sop,
  input  logic             in_eop,
  input  logic [7:0]       in_byte,
  input  logic             in_ctrl_bad,
  input  logic             in_fcs_bad,
  input  logic [LEN_W-1:0] max_len,
  output logic             out_done,
  output logic [1:0]       err_code,
  output logic             err_flag,
  output logic [2:0]       status_code
);

  logic [LEN_W-1:0] len_nxt, hend_nxt;
  frm_info_t        info_nxt;
  logic [1:0]       err_c;
  logic [2:0]       st_c;
  logic             fire;

  rxcls_hdr_parser #(.LEN_W(LEN_W), .MAX_TAGS(MAX_TAGS)) u_parse (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_sop   (in_sop),
    .in_byte  (in_byte),
    .in_ctrl  (in_ctrl_bad),
    .len_nxt  (len_nxt),
    .hend_nxt (hend_nxt),
    .info_nxt (info_nxt)
  );

  rxcls_err_eval #(.LEN_W(LEN_W)) u_err (
    .len     (len_nxt),
    .hend    (hend_nxt),
    .max_len (max_len),
    .ctl_bad (info_nxt.ctl_bad),
    .typ_ok  (info_nxt.typ_ok),
    .typ     (info_nxt.typ),
    .code    (err_c)
  );

  rxcls_status_prio u_stat (
    .grp    (info_nxt.grp),
    .svl    (info_nxt.svl),
    .typ_ok (info_nxt.typ_ok),
    .typ    (info_nxt.typ),
    .opc_ok (info_nxt.opc_ok),
    .opc    (info_nxt.opc),
    .code   (st_c)
  );

  assign fire = in_valid && in_eop;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_done    <= 1'b0;
      err_code    <= ERR_NONE;
      err_flag    <= 1'b0;
      status_code <= 3'd0;
    end else begin
      out_done    <= fire;
      err_code    <= fire ? err_c : ERR_NONE;
      err_flag    <= fire && ((err_c != ERR_NONE) || in_fcs_bad);
      status_code <= fire ? st_c : 3'd0;
    end
  end

endmodule

// File: rtl/rxcls_chk.sv
module rxcls_chk (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       in_eop,
  input logic       in_fcs_bad,
  input logic       out_done,
  input logic [1:0] err_code,
  input logic       err_flag,
  input logic [2:0] status_code
);

  assert_done_follows_eop_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_eop |=> out_done);

  assert_done_has_cause_R1: assert property (@(posedge clk) disable iff (rst)
    out_done |-> $past(in_valid && in_eop));

  assert_quiet_when_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !out_done |-> (err_code == 2'd0 && status_code == 3'd0 && !err_flag));

  assert_flag_covers_code_R5: assert property (@(posedge clk) disable iff (rst)
    out_done && err_code != 2'd0 |-> err_flag);

  assert_fcs_raises_flag_R5: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_eop && in_fcs_bad |=> err_flag);

  assert_flag_has_reason_R5: assert property (@(posedge clk) disable iff (rst)
    out_done && err_flag && err_code == 2'd0 |-> $past(in_fcs_bad));

endmodule

bind rxcls_top rxcls_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_eop      (in_eop),
  .in_fcs_bad  (in_fcs_bad),
  .out_done    (out_done),
  .err_code    (err_code),
  .err_flag    (err_flag),
  .status_code (status_code)
);

// File: tb/sim_rxcls_top.sv
module sim_rxcls_top;

  localparam int LW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic [7:0]    in_byte = 8'd0;
  logic          in_ctrl_bad = 1'b0, in_fcs_bad = 1'b0;
  logic [LW-1:0] max_len = 16'd128;
  logic          out_done, err_flag;
  logic [1:0]    err_code;
  logic [2:0]    status_code;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  logic [7:0] fb [0:255];

  always #2 clk = ~clk;

  rxcls_top #(.LEN_W(LW), .MAX_TAGS(2)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
    .in_byte(in_byte), .in_ctrl_bad(in_ctrl_bad), .in_fcs_bad(in_fcs_bad),
    .max_len(max_len), .out_done(out_done), .err_code(err_code),
    .err_flag(err_flag), .status_code(status_code)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected result from R2..R8; tcfg: 0 none, 1 one 0x8100, 2 one 0x88A8, 3 two 0x8100
  task automatic model(input int len, input int tcfg, input int typ, input int opc,
                       input int grp, input int ctrlpos, input int fcs,
                       output int e_err, output int e_flag, output int e_st);
    int ntag, hend;
    bit tok, ook;
    bit [7:0] cat;
    int order [8] = '{5, 4, 7, 6, 1, 2, 3, 0};
    ntag = (tcfg == 0) ? 0 : (tcfg == 3) ? 2 : 1;
    hend = 12 + 4 * ntag + 2;
    tok  = len >= hend;
    ook  = len >= hend + 2;
    if (ctrlpos >= 0 && ctrlpos < len)         e_err = 1;
    else if (len < 64 || len > int'(max_len))  e_err = 2;
    else if (tok && typ <= 1500 && len < typ + hend + 4) e_err = 3;
    else                                       e_err = 0;
    e_flag = (e_err != 0 || fcs != 0) ? 1 : 0;
    cat = '0;
    cat[5] = tcfg >= 2;
    cat[7] = tok && typ == 'h8808;
    cat[4] = cat[7] && ook && opc == 'h0101;
    cat[6] = !tok || (typ > 1500 && typ < 'h600);
    cat[1] = tok && typ >= 'h600 && typ != 'h8808 && typ != 'h88F7;
    cat[2] = grp != 0;
    cat[3] = tok && typ == 'h88F7;
    cat[0] = tok && typ <= 1500;
    e_st = 0;
    for (int k = 7; k >= 0; k--) if (cat[order[k]]) e_st = order[k];
  endtask

  task automatic build(input int tcfg, input int typ, input int opc, input int grp);
    int p;
    for (int i = 0; i < 256; i++) fb[i] = 8'(i * 7 + 3);
    fb[0] = {7'h2A, grp[0]};
    p = 12;
    if (tcfg != 0) begin
      fb[p] = (tcfg == 2) ? 8'h88 : 8'h81;
      fb[p+1] = (tcfg == 2) ? 8'hA8 : 8'h00;
      p += 4;
    end
    if (tcfg == 3) begin
      fb[p] = 8'h81; fb[p+1] = 8'h00; p += 4;
    end
    fb[p] = 8'(typ >> 8); fb[p+1] = 8'(typ);
    fb[p+2] = 8'(opc >> 8); fb[p+3] = 8'(opc);
  endtask

  // called at a negedge; returns at the negedge after the last byte
  task automatic send(input int len, input int tcfg, input int typ, input int opc,
                      input int grp, input int ctrlpos, input int fcs,
                      input bit gaps, input int abort);
    int n, e_err, e_flag, e_st;
    bit quiet;
    string tg;
    n = (abort > 0) ? abort : len;
    quiet = 1'b1;
    build(tcfg, typ, opc, grp);
    for (int i = 0; i < n; i++) begin
      if (gaps && (i % 5) == 2) begin
        // R9: junk beats with valid low
        in_valid = 1'b0; in_sop = 1'b1; in_eop = 1'b1; in_byte = 8'h88;
        in_ctrl_bad = 1'b1; in_fcs_bad = 1'b1;
        @(negedge clk);
        if (out_done) quiet = 1'b0;
      end
      in_valid = 1'b1;
      in_sop = (i == 0);
      in_eop = (i == len - 1) && (abort == 0);
      in_byte = fb[i];
      in_ctrl_bad = (i == ctrlpos);
      in_fcs_bad = (fcs != 0) && (i == len - 1);
      @(negedge clk);
      if (i != n - 1 || abort != 0) if (out_done) quiet = 1'b0;
    end
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_ctrl_bad = 1'b0; in_fcs_bad = 1'b0;
    chk("R1/R9 no strobe inside frame", int'(quiet), 1);
    if (abort != 0) return;
    model(len, tcfg, typ, opc, grp, ctrlpos, fcs, e_err, e_flag, e_st);
    chk("R1 done strobe", int'(out_done), 1);
    tg = (e_err == 1) ? "R2 err_code" : (e_err == 2) ? "R3 err_code" :
         (e_err == 3) ? "R4 err_code" : "R4 err_code none";
    chk(tg, int'(err_code), e_err);
    chk("R5 err_flag", int'(err_flag), e_flag);
    chk(tcfg != 0 ? "R6 R8 status_code" : "R7 R8 status_code", int'(status_code), e_st);
  endtask

  initial begin
    int typs [8] = '{16, 46, 1500, 1520, 'h0800, 'h8808, 'h8808, 'h88F7};
    int lens [5] = '{40, 64, 70, 128, 129};
    int k, ln;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset done", int'(out_done), 0);
    chk("R1 reset err", int'(err_code), 0);
    chk("R1 reset flag", int'(err_flag), 0);
    chk("R1 reset status", int'(status_code), 0);

    // R6 R7 R8 R2 R3 R4 R5 R9 sweep
    k = 0;
    for (int tc = 0; tc < 4; tc++)
      for (int ti = 0; ti < 8; ti++)
        for (int g = 0; g < 2; g++)
          for (int li = 0; li < 5; li++) begin
            ln = lens[li];
            send(ln, tc, typs[ti], (ti == 6) ? 'h0101 : 'h0001, g,
                 (k % 11 == 0) ? (k % ln) : -1, (k % 7 == 3) ? 1 : 0,
                 (k % 3 == 1), 0);
            k++;
          end

    // R3 R7 short frames: type incomplete or just complete
    send(1, 0, 'h0800, 1, 1, -1, 0, 0, 0);
    send(13, 0, 'h0800, 1, 0, -1, 0, 0, 0);
    send(14, 0, 'h0800, 1, 0, -1, 0, 1, 0);
    send(63, 0, 'h0800, 1, 0, -1, 1, 0, 0);
    // R2 control character on the final byte
    send(64, 0, 'h0800, 1, 0, 63, 0, 0, 0);
    // R10 abandoned frame with a control character, then a clean frame
    send(64, 0, 'h0800, 1, 0, 3, 0, 0, 20);
    send(64, 0, 'h0800, 1, 0, -1, 0, 0, 0);
    // R3 maximum length boundary after a change
    max_len = 16'd100;
    send(100, 0, 'h0800, 1, 0, -1, 0, 0, 0);
    send(101, 0, 'h0800, 1, 0, -1, 0, 0, 0);
    // R4 exact payload fit and one short
    send(64, 0, 46, 1, 0, -1, 0, 0, 0);
    send(63 + 4 + 18, 1, 64, 1, 0, -1, 0, 0, 0);
    // R1 strobe lasts one cycle
    @(negedge clk);
    chk("R1 single-cycle strobe", int'(out_done), 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule